// File: doc/BRIEF.md
# PTP Receive Timestamp Snapshot Queue

This block records when qualifying PTP event frames arrive. Each time the frame parser pulses `frame_det`, the block checks the message-type code against the node's current role. A slave captures on Sync messages and a master captures on Delay_Req messages. On a qualifying frame it stores one record in a 16-entry queue. The record holds the 64-bit system time, the 80-bit source port identity and the 16-bit sequence ID.

Host firmware sees the oldest record through a 16-bit read window. A status bit is set while the queue holds records. Writing one to that bit removes the oldest record. The bit therefore clears only when the queue runs empty, so firmware drains the queue by reading and clearing in a loop. An interrupt line follows the status bit, gated by an enable bit.

Top module: `ptp_rx_snap_queue`

## Requirements
- R1: With `role_master`=0, a `frame_det` pulse with `msg_type`=4'h0 (Sync) stores one record, taken from the inputs sampled at that clock edge.
- R2: With `role_master`=1, a `frame_det` pulse with `msg_type`=4'h1 (Delay_Req) stores one record.
- R3: A `frame_det` pulse with any other combination of type and role stores nothing. After such a pulse, `rx_status` and `rd_data` are unchanged.
- R4: `rd_data` shows one 16-bit word of the oldest record, chosen by `rd_win`:
  - 0..3 select `sys_time` words, least significant first.
  - 4..8 select `src_port_id` words, least significant first.
  - 9 selects `seq_id`.
  - Values 10..15 read 0. An empty queue reads 0 for every value.
- R5: The queue holds at most 16 records. A qualifying frame that arrives while the queue is full, with no removal in the same cycle, is dropped and the stored records are kept.
- R6: `rx_status` is 1 in the cycle after a record is stored.
- R7: A `status_w1c` pulse while the queue is non-empty removes the oldest record. `rx_status` stays 1 while records remain and goes to 0 once the last record is removed. A `status_w1c` pulse on an empty queue has no effect.
- R8: `rx_irq` is 1 exactly when `rx_status` and `rx_int_en` are both 1.
- R9: If a record is stored and another is removed in the same cycle, the occupancy is unchanged and the new record is kept at the tail. This also holds when the queue is full.
- R10: A synchronous `rst` empties the queue, clears `rx_status` and deasserts `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_det | input | 1 | One-cycle pulse: a PTP event frame was detected |
| msg_type | input | 4 | PTP message-type code of the detected frame |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| sys_time | input | 64 | Current local system time |
| src_port_id | input | 80 | Source port identity of the frame |
| seq_id | input | 16 | Sequence ID of the frame |
| status_w1c | input | 1 | Host write of one to the receive-status bit |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_win | input | 4 | Read window select |
| rx_status | output | 1 | Receive status: records are queued |
| rx_irq | output | 1 | Receive interrupt to the host |
| rd_data | output | 16 | Selected word of the oldest record |

## Verification
A capture or a removal registered at clock edge k shows up on `rx_status`, `rx_irq` and `rd_data` right after edge k. There is no further pipeline stage. `rd_data` and `rx_irq` are combinational from `rd_win`, `rx_int_en` and the stored state. The bench drives the inputs of each cycle before the clock edge. It compares the outputs at the following falling edge, stepping `rd_win` through all sixteen values within that half period. The expected values come from a queue model in the bench that applies the removal before the append, using the occupancy before the edge.

// File: rtl/ptp_rxq_pkg.sv
package ptp_rxq_pkg;

    localparam int TIME_W  = 64;
    localparam int SRC_W   = 80;
    localparam int SEQ_W   = 16;
    localparam int WORD_W  = 16;
    localparam int SEL_W   = 4;

    localparam int TIME_WORDS = TIME_W / WORD_W;
    localparam int SRC_WORDS  = SRC_W / WORD_W;
    localparam int SEQ_WORDS  = SEQ_W / WORD_W;
    localparam int WIN_COUNT  = TIME_WORDS + SRC_WORDS + SEQ_WORDS;

    typedef enum logic [3:0] {
        MSG_SYNC      = 4'h0,
        MSG_DELAY_REQ = 4'h1
    } ptp_msg_e;

    // Record layout: time in the low bits, then the source identity, then the sequence ID.
    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [SRC_W-1:0]  src;
        logic [TIME_W-1:0] stamp;
    } snap_rec_t;

    localparam int REC_W = $bits(snap_rec_t);

    // Masters time-stamp incoming delay requests; slaves time-stamp incoming syncs.
    function automatic logic event_for_role(logic [3:0] code, logic master);
        return master ? (code == MSG_DELAY_REQ) : (code == MSG_SYNC);
    endfunction

endpackage

// File: rtl/ptp_rxq_qual.sv
module ptp_rxq_qual
    import ptp_rxq_pkg::*;
(
    input  logic       frame_det,
    input  logic [3:0] msg_type,
    input  logic       role_master,
    output logic       capture_req
);
    always_comb capture_req = frame_det && event_for_role(msg_type, role_master);
endmodule

// File: rtl/ptp_rxq_fifo.sv
module ptp_rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 160,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             accept,
    output logic             empty,
    output logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (fill == FULL_CNT);
        empty  = (fill == '0);
        // A removal in the same cycle frees the slot a full queue needs.
        accept = push_req && (!full || pop);
        rdata  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (pop)    rd_ptr <= bump(rd_ptr);
            case ({accept, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ptp_rxq_rdmux.sv
module ptp_rxq_rdmux
    import ptp_rxq_pkg::*;
(
    input  snap_rec_t          head,
    input  logic               valid,
    input  logic [SEL_W-1:0]   sel,
    output logic [WORD_W-1:0]  data
);
    logic [REC_W-1:0]  flat;
    logic [WORD_W-1:0] words [WIN_COUNT];

    assign flat = head;

    for (genvar gi = 0; gi < WIN_COUNT; gi++) begin : g_word
        assign words[gi] = flat[gi*WORD_W +: WORD_W];
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < WIN_COUNT; i++) begin
            if (valid && (int'(sel) == i)) data = words[i];
        end
    end
endmodule

// File: rtl/ptp_rx_snap_queue.sv
module ptp_rx_snap_queue
    import ptp_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_det,
    input  logic [3:0]           msg_type,
    input  logic                 role_master,
    input  logic [TIME_W-1:0]    sys_time,
    input  logic [SRC_W-1:0]     src_port_id,
    input  logic [SEQ_W-1:0]     seq_id,
    input  logic                 status_w1c,
    input  logic                 rx_int_en,
    input  logic [SEL_W-1:0]     rd_win,
    output logic                 rx_status,
    output logic                 rx_irq,
    output logic [WORD_W-1:0]    rd_data
);
    logic             capture_req, accept, pop_w, empty_w;
    logic [CNT_W-1:0] fill_w;
    snap_rec_t        new_rec, head_rec;
    logic [REC_W-1:0] head_flat;
    logic             status_q;

    always_comb begin
        new_rec.stamp = sys_time;
        new_rec.src   = src_port_id;
        new_rec.seq   = seq_id;
        head_rec      = snap_rec_t'(head_flat);
    end

    ptp_rxq_qual qual_i (
        .frame_det   (frame_det),
        .msg_type    (msg_type),
        .role_master (role_master),
        .capture_req (capture_req)
    );

    // A write of one only removes a record when there is one to remove.
    assign pop_w = status_w1c && !empty_w;

    ptp_rxq_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) fifo_i (
        .clk      (clk),
        .rst      (rst),
        .push_req (capture_req),
        .pop      (pop_w),
        .wdata    (new_rec),
        .rdata    (head_flat),
        .accept   (accept),
        .empty    (empty_w),
        .fill     (fill_w)
    );

    // Status sets on a stored record; a clear takes effect only on the last record.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else if (accept) begin
            status_q <= 1'b1;
        end else if (pop_w && fill_w == CNT_W'(1)) begin
            status_q <= 1'b0;
        end
    end

    ptp_rxq_rdmux rdmux_i (
        .head  (head_rec),
        .valid (!empty_w),
        .sel   (rd_win),
        .data  (rd_data)
    );

    assign rx_status = status_q;
    assign rx_irq    = status_q && rx_int_en;
endmodule

// File: rtl/ptp_rxq_checker.sv
module ptp_rxq_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             capture_req,
    input logic             pop,
    input logic [CNT_W-1:0] fill,
    input logic             rx_status,
    input logic             rx_int_en,
    input logic             rx_irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_CNT);

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (fill == FULL_CNT && capture_req && !pop) |=> $stable(fill));

    assert_capture_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (capture_req && (fill != FULL_CNT || pop)) |=> rx_status);

    assert_status_tracks_fill_R7: assert property (@(posedge clk) disable iff (rst)
        rx_status == (fill != '0));

    assert_last_pop_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (fill == CNT_W'(1) && pop && !capture_req) |=> !rx_status);

    assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_status && rx_int_en));

    assert_same_cycle_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (capture_req && pop) |=> $stable(fill));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fill == '0 && !rx_status && !rx_irq));
endmodule

bind ptp_rx_snap_queue ptp_rxq_checker #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .capture_req (capture_req),
    .pop         (pop_w),
    .fill        (fill_w),
    .rx_status   (rx_status),
    .rx_int_en   (rx_int_en),
    .rx_irq      (rx_irq)
);

// File: tb/ptp_rx_snap_queue_tb.sv
`timescale 1ns/100ps
module ptp_rx_snap_queue_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_det = 1'b0;
    logic [3:0]  msg_type = '0;
    logic        role_master = 1'b0;
    logic [63:0] sys_time = '0;
    logic [79:0] src_port_id = '0;
    logic [15:0] seq_id = '0;
    logic        status_w1c = 1'b0;
    logic        rx_int_en = 1'b0;
    logic [3:0]  rd_win = '0;
    logic        rx_status, rx_irq;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [159:0] mq[$];

    always #2 clk = ~clk;

    ptp_rx_snap_queue #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .frame_det(frame_det), .msg_type(msg_type),
        .role_master(role_master), .sys_time(sys_time), .src_port_id(src_port_id),
        .seq_id(seq_id), .status_w1c(status_w1c), .rx_int_en(rx_int_en),
        .rd_win(rd_win), .rx_status(rx_status), .rx_irq(rx_irq), .rd_data(rd_data)
    );

    function automatic bit qualifies(logic det, logic [3:0] mt, logic master);
        return det && (master ? (mt == 4'h1) : (mt == 4'h0));
    endfunction

    function automatic logic [15:0] exp_word(int w);
        if (mq.size() == 0 || w > 9) return 16'h0;
        return mq[0][w*16 +: 16];
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; finishes within the half period.
    task automatic check_all(string tag);
        logic exp_stat;
        exp_stat = (mq.size() != 0);
        chk(tag, "rx_status (R6/R7)", 64'(rx_status), 64'(exp_stat));
        chk(tag, "rx_irq (R8)", 64'(rx_irq), 64'(exp_stat && rx_int_en));
        for (int w = 0; w < 16; w++) begin
            rd_win = 4'(w);
            #0.1;
            chk(tag, $sformatf("rd_data win %0d (R4)", w), 64'(rd_data), 64'(exp_word(w)));
        end
    endtask

    task automatic do_cycle(string tag, logic det, logic [3:0] mt, logic master, logic clr);
        bit q, pop;
        frame_det   = det;
        msg_type    = mt;
        role_master = master;
        status_w1c  = clr;
        sys_time    = {$urandom, $urandom};
        src_port_id = {16'($urandom), $urandom, $urandom};
        seq_id      = 16'($urandom);
        q   = qualifies(det, mt, master);
        pop = clr && (mq.size() != 0);
        if (q && (mq.size() < DEPTH || pop)) mq.push_back({seq_id, src_port_id, sys_time});
        if (pop) void'(mq.pop_front());
        @(negedge clk);
        frame_det  = 1'b0;
        status_w1c = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        frame_det = 1'b0;
        status_w1c = 1'b0;
        mq.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset("R10");

        // Role qualification
        rx_int_en = 1'b1;
        do_cycle("R1", 1, 4'h0, 0, 0);
        do_cycle("R3", 1, 4'h1, 0, 0);
        do_cycle("R2", 1, 4'h1, 1, 0);
        do_cycle("R3", 1, 4'h0, 1, 0);
        do_cycle("R3", 1, 4'h2, 0, 0);
        do_cycle("R3", 0, 4'h0, 0, 0);
        rx_int_en = 1'b0;
        do_cycle("R8", 0, 4'h0, 0, 0);
        rx_int_en = 1'b1;
        do_cycle("R7", 0, 4'h0, 0, 1);
        do_cycle("R7", 0, 4'h0, 0, 1);
        do_cycle("R7", 0, 4'h0, 0, 1);

        // Fill past capacity, then drain
        for (int i = 0; i < DEPTH + 2; i++) do_cycle("R5", 1, 4'h0, 0, 0);
        chk("R5", "model occupancy", 64'(mq.size()), 64'(DEPTH));
        do_cycle("R9", 1, 4'h0, 0, 1);
        do_cycle("R9", 1, 4'h1, 1, 1);
        for (int i = 0; i < DEPTH; i++) do_cycle("R7", 0, 4'h0, 0, 1);
        do_cycle("R7", 0, 4'h0, 0, 1);
        do_cycle("R6", 1, 4'h1, 1, 0);
        do_cycle("R9", 1, 4'h1, 1, 1);
        do_cycle("R6", 0, 4'h0, 0, 0);

        // Reset with records present
        do_cycle("R1", 1, 4'h0, 0, 0);
        do_reset("R10");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [3:0] mt = (r < 70) ? 4'(r % 2) : 4'($urandom_range(2, 15));
            if ((n % 200) == 0) rx_int_en = 1'($urandom);
            do_cycle("R4", 1'($urandom_range(0, 99) < 55), mt, 1'($urandom),
                     1'($urandom_range(0, 99) < 40));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule